// File: doc/BRIEF.md
# FP8 Pair Dot-Accumulate Unit

This unit takes two pairs of 8-bit floating-point numbers, one pair from each operand, and multiplies the elements that share a position. It adds the two products together and divides that sum by a power of two given by a scale input. The scaled sum is then added to a single-precision accumulator. The two products, the scaling and the addition are all carried out exactly, and the result is rounded only once, to single precision.

Each operand has its own format-select bit, so E5M2 data can be multiplied against E4M3 data. The unit has no enable mask: every accepted beat produces a new accumulator value. That value is registered and appears one cycle after the beat is presented. A wider array would place one instance of this unit in each lane.

Top module: `fp8dot_acc`

## Requirements
- R1: Each 16-bit operand holds element 0 in bits [7:0] and element 1 in bits [15:8]. The result equals acc + (a0*b0 + a1*b1) * 2^-scale. Select value 0 decodes a byte as E5M2: sign bit 7, exponent bits [6:2] with bias 15, fraction bits [1:0]. Select value 1 decodes a byte as E4M3: sign bit 7, exponent bits [6:3] with bias 7, fraction bits [2:0]. In both formats an exponent field of zero encodes a subnormal.
- R2: `fmt_a` selects the format of both bytes of `op_a`, and `fmt_b` selects the format of both bytes of `op_b`. The two selects are independent of each other.
- R3: The sum of the two products is multiplied by 2^-scale, where `scale` is read as an unsigned number from 0 to 63. This scaling is exact.
- R4: The products, the scaling and the addition to the accumulator are all exact. Exactly one round-to-nearest-even step into IEEE single precision is applied to the final value.
- R5: Results smaller than the normal range come out as single-precision subnormals. A nonzero exact sum never rounds to zero.
- R6: A NaN on any input produces 0x7FC00000. In E5M2 a NaN is exponent 31 with a nonzero fraction. In E4M3 the only NaN is S.1111.111. In single precision a NaN is exponent 255 with a nonzero fraction. Every NaN the unit emits has the value 0x7FC00000.
- R7: An E5M2 infinity is exponent 31 with fraction 0; E4M3 has no infinity. An infinity multiplied by a zero gives 0x7FC00000. Infinities of opposite sign, whether two products or a product and the accumulator, give 0x7FC00000. Any other infinity gives an infinity of that sign (0x7F800000 or 0xFF800000).
- R8: An exactly zero result is -0 (0x80000000) only when the accumulator is -0 and both products are zeros of negative sign. Every other exactly zero result is +0.
- R9: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. On that same cycle `result` holds the value for that beat.
- R10: A cycle with `in_valid` low leaves `result` unchanged, whatever the other inputs are doing.
- R11: While `rst_n` is low, `out_valid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Beat strobe for the operand inputs |
| op_a | input | 16 | First operand pair, element 0 in the low byte |
| op_b | input | 16 | Second operand pair, element 0 in the low byte |
| fmt_a | input | 1 | Format of `op_a` (0 E5M2, 1 E4M3) |
| fmt_b | input | 1 | Format of `op_b` (0 E5M2, 1 E4M3) |
| scale | input | SCALE_W (6) | Unsigned down-scale exponent |
| acc_in | input | 32 | Single-precision accumulator addend |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 32 | Registered single-precision result |

## Verification
The assertions check the timing of the valid strobe on every cycle, along with the hold of `result` on idle cycles. They also check that every NaN the unit emits is the single canonical code, and that an accumulator NaN or an infinity-times-zero input leads to that code. Inside the datapath they check that the exact sum fits its field and that a nonzero sum never rounds to zero. Only the bench's scenarios can show that rounding is correct to the last bit. The same holds for the format decoding of each select, the exact scaling, the signs of zeros and the ordering of special values. The bench compares every beat against an exact wide-integer model.

// File: rtl/fp8dot_pkg.sv
package fp8dot_pkg;

   // Decoded FP8 element: value = sig * 2^k (sig includes hidden bit)
   typedef struct packed {
      logic              sign;
      logic [3:0]        sig;
      logic signed [6:0] k;
      logic              is_zero;
      logic              is_inf;
      logic              is_nan;
   } fp8_unp_t;

   localparam logic        FMT_E5M2  = 1'b0;
   localparam logic [31:0] SP_QNAN   = 32'h7FC0_0000;
   localparam logic [31:0] SP_PINF   = 32'h7F80_0000;
   localparam logic [31:0] SP_NINF   = 32'hFF80_0000;

endpackage

// File: rtl/fp8_unpack.sv
module fp8_unpack
   import fp8dot_pkg::*;
(
   input  logic [7:0] code,
   input  logic       fmt,
   output fp8_unp_t   val
);

   logic [4:0] e5_eff;
   logic [3:0] e4_eff;

   assign e5_eff = (code[6:2] == 5'd0) ? 5'd1 : code[6:2];
   assign e4_eff = (code[6:3] == 4'd0) ? 4'd1 : code[6:3];

   always_comb begin
      val      = '0;
      val.sign = code[7];
      if (fmt == FMT_E5M2) begin
         // sig carries an extra zero LSB so both formats share a 4-bit field
         val.sig    = {(code[6:2] != 5'd0), code[1:0], 1'b0};
         val.k      = $signed({2'b00, e5_eff}) - 7'sd18;
         val.is_nan = (code[6:2] == 5'd31) && (code[1:0] != 2'd0);
         val.is_inf = (code[6:2] == 5'd31) && (code[1:0] == 2'd0);
      end else begin
         val.sig    = {(code[6:3] != 4'd0), code[2:0]};
         val.k      = $signed({3'b000, e4_eff}) - 7'sd10;
         val.is_nan = (code[6:0] == 7'h7F);
         val.is_inf = 1'b0;
      end
      val.is_zero = (val.sig == 4'd0);
   end

endmodule

// File: rtl/fp8dot_term.sv
module fp8dot_term
   import fp8dot_pkg::*;
#(
   parameter int FRAC_W  = 160,
   parameter int W       = 292,
   parameter int SCALE_W = 6
) (
   input  fp8_unp_t               a,
   input  fp8_unp_t               b,
   input  logic [SCALE_W-1:0]     scale,
   output logic signed [W+1:0]    term,
   output logic                   t_nan,
   output logic                   t_inf,
   output logic                   t_sign,
   output logic                   t_zero_neg
);

   localparam int SHW = 12;

   logic [7:0]            prod;
   logic signed [SHW-1:0] ka, kb, sh;
   logic [W-1:0]          mag;
   logic signed [W+1:0]   smag;

   assign prod = a.sig * b.sig;
   assign ka   = {{(SHW-7){a.k[6]}}, a.k};
   assign kb   = {{(SHW-7){b.k[6]}}, b.k};
   // Bit position of the product LSB in the fixed-point window
   assign sh   = ka + kb - SHW'(scale) + SHW'(FRAC_W);

   assign mag    = W'(prod) << sh[SHW-2:0];
   assign smag   = $signed({2'b00, mag});
   assign t_sign = a.sign ^ b.sign;
   assign term   = t_sign ? -smag : smag;

   assign t_nan      = a.is_nan | b.is_nan | (a.is_inf & b.is_zero) | (b.is_inf & a.is_zero);
   assign t_inf      = (a.is_inf | b.is_inf) & ~t_nan;
   assign t_zero_neg = (prod == 8'd0) & t_sign;

   // R3: scaled product never lands below the window
   always_comb begin
      a_r3_shift_nonneg: assert (sh >= 0);
   end

endmodule

// File: rtl/fp32_round.sv
module fp32_round #(
   parameter int W      = 292,
   parameter int FRAC_W = 160
) (
   input  logic [W-1:0] mag,
   output logic [30:0]  bits
);

   localparam int DEN_LSB = FRAC_W - 149;   // window position of 2^-149
   localparam int IDXW    = $clog2(W);

   int          lead;
   int          lsb;
   logic [W-1:0] shr;
   logic [W-1:0] shl;
   logic         guard, sticky, rnd;
   logic [24:0]  qr;
   logic [47:0]  packed_w;

   always_comb begin
      lead = 0;
      for (int i = 0; i < W; i++) begin
         if (mag[i]) lead = i;
      end
      lsb    = (lead - 23 > DEN_LSB) ? lead - 23 : DEN_LSB;
      shr    = mag >> lsb;
      guard  = mag[IDXW'(lsb - 1)];
      shl    = mag << (W - lsb + 1);
      sticky = (shl != '0);
      rnd    = guard & (sticky | shr[0]);
      qr     = {1'b0, shr[23:0]} + 25'(rnd);
      // exponent field minus one sits above the significand; carries fold in
      packed_w = (48'(lsb - DEN_LSB) << 23) + 48'(qr);
      bits     = (packed_w >= 48'h7F80_0000) ? 31'h7F80_0000 : packed_w[30:0];
   end

   always_comb begin
      a_r4_sig_fits: assert (shr[W-1:24] == '0);
      if (mag != '0) begin
         a_r5_no_flush: assert (bits != '0);
      end
   end

endmodule

// File: rtl/fp8dot_acc.sv
module fp8dot_acc
   import fp8dot_pkg::*;
#(
   parameter int FRAC_W  = 160,
   parameter int INT_W   = 132,
   parameter int SCALE_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [15:0]        op_a,
   input  logic [15:0]        op_b,
   input  logic               fmt_a,
   input  logic               fmt_b,
   input  logic [SCALE_W-1:0] scale,
   input  logic [31:0]        acc_in,
   output logic               out_valid,
   output logic [31:0]        result
);

   localparam int W     = FRAC_W + INT_W;
   localparam int NLANE = 2;

   // elaboration checks on the fixed-point window
   if (FRAC_W < 150) begin : g_chk_frac_acc
      $error("FRAC_W must reach below the smallest single-precision subnormal");
   end
   if (FRAC_W < 34 + (1 << SCALE_W) - 1) begin : g_chk_frac_prod
      $error("FRAC_W too small for the deepest scaled product");
   end
   if (INT_W < 130) begin : g_chk_int
      $error("INT_W too small for the largest accumulator");
   end
   if (W > 1024) begin : g_chk_size
      $error("fixed-point window unreasonably wide");
   end

   fp8_unp_t            ua [NLANE];
   fp8_unp_t            ub [NLANE];
   logic signed [W+1:0] term [NLANE];
   logic [NLANE-1:0]    p_nan, p_inf, p_sign, p_zneg;

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      fp8_unpack u_ua (.code(op_a[8*g +: 8]), .fmt(fmt_a), .val(ua[g]));
      fp8_unpack u_ub (.code(op_b[8*g +: 8]), .fmt(fmt_b), .val(ub[g]));
      fp8dot_term #(.FRAC_W(FRAC_W), .W(W), .SCALE_W(SCALE_W)) u_term (
         .a          (ua[g]),
         .b          (ub[g]),
         .scale      (scale),
         .term       (term[g]),
         .t_nan      (p_nan[g]),
         .t_inf      (p_inf[g]),
         .t_sign     (p_sign[g]),
         .t_zero_neg (p_zneg[g])
      );
   end

   // accumulator expanded into the same window
   logic [7:0]          acc_exp;
   logic [22:0]         acc_frac;
   logic                acc_nan, acc_inf, acc_zneg;
   int                  acc_sh;
   logic [W-1:0]        acc_mag;
   logic signed [W+1:0] acc_term;

   assign acc_exp  = acc_in[30:23];
   assign acc_frac = acc_in[22:0];
   assign acc_nan  = (acc_exp == 8'hFF) && (acc_frac != '0);
   assign acc_inf  = (acc_exp == 8'hFF) && (acc_frac == '0);
   assign acc_zneg = acc_in[31] && (acc_in[30:0] == '0);
   assign acc_sh   = int'((acc_exp == 8'd0) ? 8'd1 : acc_exp) + FRAC_W - 150;
   assign acc_mag  = W'({(acc_exp != 8'd0), acc_frac}) << acc_sh;
   assign acc_term = acc_in[31] ? -$signed({2'b00, acc_mag}) : $signed({2'b00, acc_mag});

   // exact sum and rounding
   logic signed [W+1:0] sum;
   logic [W+1:0]        sum_abs;
   logic                sum_neg;
   logic [30:0]         rounded;

   assign sum     = term[0] + term[1] + acc_term;
   assign sum_neg = sum[W+1];
   assign sum_abs = sum_neg ? -sum : sum;

   fp32_round #(.W(W), .FRAC_W(FRAC_W)) u_round (
      .mag  (sum_abs[W-1:0]),
      .bits (rounded)
   );

   always_comb begin
      a_r4_sum_fits: assert (sum_abs[W+1:W] == 2'b00);
   end

   // special-value resolution
   logic        any_nan, pos_inf, neg_inf;
   logic [31:0] next_res;

   always_comb begin
      any_nan = acc_nan | (|p_nan);
      pos_inf = acc_inf & ~acc_in[31];
      neg_inf = acc_inf &  acc_in[31];
      for (int i = 0; i < NLANE; i++) begin
         pos_inf |= p_inf[i] & ~p_sign[i];
         neg_inf |= p_inf[i] &  p_sign[i];
      end
      if (any_nan || (pos_inf && neg_inf)) next_res = SP_QNAN;
      else if (pos_inf)                    next_res = SP_PINF;
      else if (neg_inf)                    next_res = SP_NINF;
      else if (sum_abs == '0)              next_res = {acc_zneg & (&p_zneg), 31'd0};
      else                                 next_res = {sum_neg, rounded};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= next_res;
      end
   end

   a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r9_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));
   a_r6_acc_nan: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && acc_in[30:23] == 8'hFF && acc_in[22:0] != '0) |=> result == SP_QNAN);
   a_r6_canonical: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && result[30:23] == 8'hFF && result[22:0] != '0) |-> result == SP_QNAN);
   a_r7_inf_times_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !fmt_a && op_a[6:0] == 7'h7C && op_b[6:0] == 7'h00) |=> result == SP_QNAN);

endmodule

// File: tb/fp8dot_acc_test.sv
module fp8dot_acc_test;

   localparam int CLK_PERIOD = 10;
   localparam int BW         = 440;
   localparam int BASE       = 220;   // model window LSB is 2^-BASE

   logic        clk, rst_n, in_valid, fmt_a, fmt_b, out_valid;
   logic [15:0] op_a, op_b;
   logic [5:0]  scale;
   logic [31:0] acc_in, result;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 0;
   logic [31:0] last_res;

   fp8dot_acc uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .op_a(op_a), .op_b(op_b), .fmt_a(fmt_a), .fmt_b(fmt_b),
      .scale(scale), .acc_in(acc_in),
      .out_valid(out_valid), .result(result)
   );

   initial begin
      clk = 0;
      forever #(CLK_PERIOD/2) clk = ~clk;
   end

   // ---------------- reference model ----------------
   function automatic void dec8(input logic [7:0] c, input logic f,
                                output logic s, output int m, output int e,
                                output logic nan, output logic inf);
      int ex, fr;
      s = c[7];
      if (!f) begin
         ex = int'(c[6:2]); fr = int'(c[1:0]);
         nan = (ex == 31) && (fr != 0);
         inf = (ex == 31) && (fr == 0);
         if (ex == 0) begin m = fr;     e = -16;     end
         else         begin m = 4 + fr; e = ex - 17; end
      end else begin
         ex = int'(c[6:3]); fr = int'(c[2:0]);
         nan = (ex == 15) && (fr == 7);
         inf = 0;
         if (ex == 0) begin m = fr;     e = -9;      end
         else         begin m = 8 + fr; e = ex - 10; end
      end
   endfunction

   function automatic logic [31:0] ref_dot(input logic [15:0] a, input logic [15:0] b,
                                           input logic fa, input logic fb,
                                           input logic [5:0] sc, input logic [31:0] acc);
      logic signed [BW-1:0] total;
      logic [BW-1:0] mg, t;
      logic sa, sb, na, nb, ia, ib, nanflag, pinf, ninf, zneg, rbit, st, neg;
      int ma, mb, ea, eb, ex, biased, am, ae;
      nanflag = 0; pinf = 0; ninf = 0; zneg = 1; total = '0;
      for (int i = 0; i < 2; i++) begin
         dec8(a[8*i +: 8], fa, sa, ma, ea, na, ia);
         dec8(b[8*i +: 8], fb, sb, mb, eb, nb, ib);
         if (na || nb || (ia && mb == 0) || (ib && ma == 0)) nanflag = 1;
         else if (ia || ib) begin
            if (sa ^ sb) ninf = 1; else pinf = 1;
         end
         if (!((ma * mb == 0) && (sa ^ sb))) zneg = 0;
         t = BW'(ma * mb) << (ea + eb - int'(sc) + BASE);
         total = (sa ^ sb) ? total - $signed(t) : total + $signed(t);
      end
      if (acc[30:23] == 8'hFF) begin
         if (acc[22:0] != 0) nanflag = 1;
         else if (acc[31]) ninf = 1; else pinf = 1;
      end
      if (acc != 32'h8000_0000) zneg = 0;
      if (acc[30:23] == 0) begin am = int'(acc[22:0]); ae = -149; end
      else begin am = int'({1'b1, acc[22:0]}); ae = int'(acc[30:23]) - 150; end
      t = BW'(am) << (ae + BASE);
      total = acc[31] ? total - $signed(t) : total + $signed(t);
      if (nanflag || (pinf && ninf)) return 32'h7FC0_0000;
      if (pinf) return 32'h7F80_0000;
      if (ninf) return 32'hFF80_0000;
      if (total == 0) return {zneg, 31'd0};
      neg = total[BW-1];
      mg  = neg ? -total : total;
      ex = -BASE; rbit = 0; st = 0;
      while ((mg >> 24) != 0 || ex < -149) begin
         st   = st | rbit;
         rbit = mg[0];
         mg   = mg >> 1;
         ex++;
      end
      if (rbit && (st || mg[0])) mg = mg + 1;
      if (mg == (BW'(1) << 24)) begin mg = mg >> 1; ex++; end
      if (mg < (BW'(1) << 23)) return {neg, 8'd0, mg[22:0]};
      biased = ex + 150;
      if (biased >= 255) return {neg, 31'h7F80_0000};
      return {neg, biased[7:0], mg[22:0]};
   endfunction

   // ---------------- checking ----------------
   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: actual=%08h expected=%08h", req, got, exp);
      end
   endtask

   // drive one beat just after a falling edge, check at the next falling edge
   task automatic apply(input string req, input logic [15:0] a, input logic [15:0] b,
                        input logic fa, input logic fb, input logic [5:0] sc,
                        input logic [31:0] acc, input logic [31:0] exp);
      in_valid = 1; op_a = a; op_b = b; fmt_a = fa; fmt_b = fb; scale = sc; acc_in = acc;
      @(negedge clk);
      check("R9 valid", {31'd0, out_valid}, 32'd1);
      check(req, result, exp);
      last_res = exp;
   endtask

   task automatic apply_m(input string req, input logic [15:0] a, input logic [15:0] b,
                          input logic fa, input logic fb, input logic [5:0] sc,
                          input logic [31:0] acc);
      apply(req, a, b, fa, fb, sc, acc, ref_dot(a, b, fa, fb, sc, acc));
   endtask

   task automatic idle_check();
      in_valid = 0;
      op_a = 16'h3838; op_b = 16'h3838; fmt_a = 1; fmt_b = 1; scale = 0; acc_in = 32'h4000_0000;
      @(negedge clk);
      check("R9 valid low", {31'd0, out_valid}, 32'd0);
      check("R10 hold", result, last_res);
   endtask

   function automatic logic [31:0] rand_acc();
      case ($urandom % 5)
         0: return $urandom;
         1: return {1'($urandom), 8'(100 + $urandom % 50), 23'($urandom)};
         2: return {1'($urandom), 31'd0};
         3: return {1'($urandom), 8'd0, 23'($urandom)};
         default: return {1'($urandom), 8'(40 + $urandom % 60), 23'($urandom)};
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fails++;
         $display("FAIL R9 watchdog: actual=hung expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      rst_n = 0; in_valid = 0; op_a = 0; op_b = 0; fmt_a = 0; fmt_b = 0; scale = 0; acc_in = 0;
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11 reset valid", {31'd0, out_valid}, 32'd0);
      check("R11 reset result", result, 32'd0);
      rst_n = 1;
      @(negedge clk);

      // R1: E4M3 1.0*1.0 + 1.0 = 2.0
      apply("R1 basic", 16'h0038, 16'h0038, 1, 1, 0, 32'h3F80_0000, 32'h4000_0000);
      // R1: both lanes, E5M2 1.0*1.0 + 1.0*1.0 = 2.0
      apply("R1 two lanes", 16'h3C3C, 16'h3C3C, 0, 0, 0, 32'h0000_0000, 32'h4000_0000);
      // R2: mixed formats, same byte read differently
      apply("R2 e5m2 x e4m3", 16'h003C, 16'h0038, 0, 1, 0, 32'h0, 32'h3F80_0000);
      apply("R2 e4m3 x e4m3", 16'h003C, 16'h0038, 1, 1, 0, 32'h0, 32'h3FC0_0000);
      // R3: scale by 2^-1 then add 1.0 = 1.5
      apply("R3 scale1", 16'h0038, 16'h0038, 1, 1, 1, 32'h3F80_0000, 32'h3FC0_0000);
      // R4: 1 + 2^-24 ties to even -> 1.0
      apply("R4 tie even", 16'h0008, 16'h0008, 1, 1, 12, 32'h3F80_0000, 32'h3F80_0000);
      // R4: 1 + 2^-24 + 2^-30 -> rounds up
      apply("R4 sticky up", 16'h0108, 16'h0108, 1, 1, 12, 32'h3F80_0000, 32'h3F80_0001);
      // R4: 1 + 2^-23 exact
      apply("R4 exact", 16'h0101, 16'h0101, 1, 1, 6, 32'h3F80_0000, 32'h3F80_0001);
      // R5: subnormal accumulator passes through
      apply("R5 subnormal", 16'h0000, 16'h0000, 1, 1, 0, 32'h0000_0005, 32'h0000_0005);
      apply_m("R5 deep scale", 16'h0101, 16'h0101, 0, 0, 63, 32'h8000_0003);
      // R6: NaNs
      apply("R6 acc nan", 16'h0038, 16'h0038, 1, 1, 0, 32'h7F80_0001, 32'h7FC0_0000);
      apply("R6 e4m3 nan", 16'h007F, 16'h0038, 1, 1, 0, 32'h0, 32'h7FC0_0000);
      apply("R6 e5m2 nan", 16'h7D00, 16'h3C00, 0, 0, 0, 32'h0, 32'h7FC0_0000);
      apply("R6 e4m3 max not nan", 16'h007E, 16'h0038, 1, 1, 0, 32'h0, 32'h43E0_0000);
      // R7: infinities
      apply("R7 inf x zero", 16'h007C, 16'h0000, 0, 0, 0, 32'h0, 32'h7FC0_0000);
      apply("R7 inf", 16'h007C, 16'h003C, 0, 0, 0, 32'h3F80_0000, 32'h7F80_0000);
      apply("R7 neg inf", 16'h00FC, 16'h003C, 0, 0, 5, 32'h0, 32'hFF80_0000);
      apply("R7 inf conflict acc", 16'h007C, 16'h003C, 0, 0, 0, 32'hFF80_0000, 32'h7FC0_0000);
      apply("R7 inf conflict prod", 16'hFC7C, 16'h3C3C, 0, 0, 0, 32'h0, 32'h7FC0_0000);
      // R8: zero signs
      apply("R8 all neg zero", 16'h8080, 16'h0000, 1, 1, 0, 32'h8000_0000, 32'h8000_0000);
      apply("R8 mixed zero", 16'h0080, 16'h0000, 1, 1, 0, 32'h8000_0000, 32'h0000_0000);
      apply("R8 cancel", 16'h0038, 16'h0038, 1, 1, 0, 32'hBF80_0000, 32'h0000_0000);
      // R10: idle cycles hold the result
      idle_check();
      idle_check();

      // R1/R2/R3/R4: random beats against the exact model
      for (int i = 0; i < 3000; i++) begin
         logic [5:0] sc;
         sc = ($urandom % 4 == 0) ? 6'($urandom) : 6'($urandom % 9);
         apply_m("R4 random", 16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
                 sc, rand_acc());
         if (i % 500 == 499) idle_check();
      end
      idle_check();

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule